// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which in-flight store a memory instruction must wait for, so that loads are held back only behind stores that have collided with them before. It keeps two tables. The membership table is indexed by instruction address and maps a load or store to a store-set number. The last-store table is indexed by set number and records the sequence number of the youngest fetched store of each set. A fetched load looks up its set and waits on the store recorded there. A fetched store is ordered behind the previous store of its set and then records itself as the youngest.

Training happens on ordering violations. The pipeline reports the address of the offending load and of the store it overtook, and the block merges them into one set. When a store issues, it presents its set number and sequence number. If it is still the youngest store of that set, the entry is retired so that later loads of the set go ahead without waiting.

Every reply is registered and appears one cycle after the fetch. A lookup always sees the tables as they stood before any update made in the same cycle.

Top module: `ssp_predictor`

## Requirements
- R1: After synchronous reset, every membership entry and every last-store entry is invalid, `rsp_vld` is low, and a fetch made right after reset gets a reply with `rsp_set_vld`=0 and `rsp_has_dep`=0.
- R2: The membership table is indexed by address bits [9:2]. Two addresses that agree in those bits share one entry, whatever their other bits.
- R3: A violation whose load entry is invalid takes the current value of a set counter and writes it into both the load entry and the store entry. This happens even when the store already had a set. The counter then advances. It starts at 0 after reset.
- R4: A violation whose load entry is valid copies the load's set number into the store entry and leaves the load entry unchanged.
- R5: A fetch with `fetch_vld` high produces `rsp_vld` high on the next cycle, together with that instruction's lookup result. `rsp_vld` is low in a cycle after a cycle with no fetch.
- R6: A load whose set is valid and whose set's last-store entry is valid gets `rsp_has_dep`=1 and `rsp_dep_inum` equal to the recorded sequence number. Otherwise `rsp_has_dep`=0 and `rsp_dep_inum`=0.
- R7: A store whose set is valid gets the same dependence reply as a load on the previous youngest store of its set. It then becomes the youngest store of that set, holding its own `fetch_inum`.
- R8: An instruction whose membership entry is invalid gets `rsp_set_vld`=0, `rsp_set_id`=0 and no dependence, and a store in that state records nothing.
- R9: A store issue retires the last-store entry of `iss_set` only when that entry is valid and holds `iss_inum`. An issue with any other sequence number has no effect.
- R10: A lookup sees the tables from before any violation update or issue retirement in the same cycle. When a store fetch and a retiring issue hit the same set in one cycle, the fetched store stays recorded.
- R11: The set counter covers 0 to 31 and wraps from 31 back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A memory instruction is being fetched |
| fetch_is_store | input | 1 | 1 for a store, 0 for a load |
| fetch_pc | input | 32 | Instruction address |
| fetch_inum | input | 16 | Sequence number of the fetched instance |
| viol_vld | input | 1 | Ordering violation reported |
| viol_ld_pc | input | 32 | Address of the load that ran too early |
| viol_st_pc | input | 32 | Address of the store it overtook |
| iss_vld | input | 1 | A store is issuing |
| iss_set | input | 5 | Set number reported for that store at fetch |
| iss_inum | input | 16 | Sequence number of the issuing store |
| rsp_vld | output | 1 | Reply valid, one cycle after the fetch |
| rsp_set_vld | output | 1 | The instruction belongs to a set |
| rsp_set_id | output | 5 | Its set number, 0 when none |
| rsp_has_dep | output | 1 | The instruction must wait on a store |
| rsp_dep_inum | output | 16 | Sequence number of that store, 0 when none |

## Verification
The hardest cases to reach are the same-cycle collisions: a violation that rewrites the entry being looked up, and a store fetch racing a retiring issue on the same set. Directed steps drive these inputs together in one cycle and compare against a reference model that reads its tables before it updates them. Counter wrap needs 32 fresh allocations, so a chain of violations on unused load addresses walks the counter past 31. A long random phase mixes fetches, violations and issues over a small address pool. It feeds back the (set, number) pairs of fetched stores so that issues actually hit live entries.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned SSP_PC_W    = 32;
  localparam int unsigned SSP_INUM_W  = 16;
  localparam int unsigned SSP_ENTRIES = 256;
  localparam int unsigned SSP_IDX_LSB = 2;
  localparam int unsigned SSP_SETS    = 32;
endpackage

// File: rtl/ssp_set_alloc.sv
module ssp_set_alloc #(
  parameter int unsigned SETS  = ssp_pkg::SSP_SETS,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  output logic [SET_W-1:0] next_id
);
  localparam logic [SET_W-1:0] LAST_ID = SET_W'(SETS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_id <= '0;
    end else if (take) begin
      if (next_id == LAST_ID) next_id <= '0;
      else                    next_id <= next_id + 1'b1;
    end
  end

  AST_ALLOC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(next_id)); // R3
  AST_ALLOC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take && next_id == LAST_ID) |=> next_id == '0); // R11
endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
  parameter int unsigned ENTRIES = ssp_pkg::SSP_ENTRIES,
  parameter int unsigned SETS    = ssp_pkg::SSP_SETS,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned SET_W  = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_vld,
  output logic [SET_W-1:0] look_id,
  input  logic             trn_we,
  input  logic [IDX_W-1:0] trn_ld_idx,
  input  logic [IDX_W-1:0] trn_st_idx,
  input  logic [SET_W-1:0] fresh_id,
  output logic             fresh_take
);
  logic [ENTRIES-1:0] ent_vld;
  logic [SET_W-1:0]   id_mem [ENTRIES];
  logic               ld_vld;
  logic [SET_W-1:0]   ld_id;
  logic [SET_W-1:0]   st_new_id;

  // reads are taken from the pre-update contents
  assign look_vld   = ent_vld[look_idx];
  assign look_id    = look_vld ? id_mem[look_idx] : '0;
  assign ld_vld     = ent_vld[trn_ld_idx];
  assign ld_id      = id_mem[trn_ld_idx];
  assign fresh_take = trn_we && !ld_vld;
  assign st_new_id  = ld_vld ? ld_id : fresh_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
    end else if (trn_we) begin
      ent_vld[trn_st_idx] <= 1'b1;
      ent_vld[trn_ld_idx] <= 1'b1;
    end
  end

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (trn_we) begin
      id_mem[trn_st_idx] <= st_new_id;
      if (!ld_vld) id_mem[trn_ld_idx] <= fresh_id;
    end
  end

  AST_TRAIN_MARKS_STORE: assert property (@(posedge clk) disable iff (rst)
    trn_we |=> ent_vld[$past(trn_st_idx)]); // R3
  AST_LOAD_SET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (trn_we && ld_vld) |=> id_mem[$past(trn_ld_idx)] == $past(ld_id)); // R4
  AST_STORE_JOINS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (trn_we && ld_vld) |=> id_mem[$past(trn_st_idx)] == $past(ld_id)); // R4
endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
  parameter int unsigned SETS   = ssp_pkg::SSP_SETS,
  parameter int unsigned INUM_W = ssp_pkg::SSP_INUM_W,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_vld,
  output logic [INUM_W-1:0] rd_inum,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [INUM_W-1:0] wr_inum,
  input  logic              clr_en,
  input  logic [SET_W-1:0]  clr_set,
  input  logic [INUM_W-1:0] clr_inum
);
  logic [SETS-1:0]   slot_vld;
  logic [INUM_W-1:0] slot_inum [SETS];
  logic [SETS-1:0]   slot_wr;
  logic [SETS-1:0]   slot_clr;

  for (genvar g = 0; g < SETS; g++) begin : g_slot
    assign slot_wr[g]  = wr_en && (wr_set == SET_W'(g));
    assign slot_clr[g] = clr_en && (clr_set == SET_W'(g)) && slot_vld[g]
                         && (slot_inum[g] == clr_inum);
  end

  assign rd_vld  = slot_vld[rd_set];
  assign rd_inum = rd_vld ? slot_inum[rd_set] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
    end else begin
      for (int s = 0; s < int'(SETS); s++) begin
        if (slot_wr[s])       slot_vld[s] <= 1'b1;
        else if (slot_clr[s]) slot_vld[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_inum[wr_set] <= wr_inum;
  end

  AST_STORE_RECORDED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> slot_vld[$past(wr_set)] && slot_inum[$past(wr_set)] == $past(wr_inum)); // R7
  AST_STALE_ISSUE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !wr_en && slot_vld[clr_set] && slot_inum[clr_set] != clr_inum)
    |=> slot_vld[$past(clr_set)]); // R9
  AST_MATCH_RETIRES: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(wr_en && wr_set == clr_set) && slot_vld[clr_set]
     && slot_inum[clr_set] == clr_inum) |=> !slot_vld[$past(clr_set)]); // R9
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor #(
  parameter int unsigned PC_W    = ssp_pkg::SSP_PC_W,
  parameter int unsigned INUM_W  = ssp_pkg::SSP_INUM_W,
  parameter int unsigned ENTRIES = ssp_pkg::SSP_ENTRIES,
  parameter int unsigned IDX_LSB = ssp_pkg::SSP_IDX_LSB,
  parameter int unsigned SETS    = ssp_pkg::SSP_SETS,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic              fetch_is_store,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic [INUM_W-1:0] fetch_inum,
  input  logic              viol_vld,
  input  logic [PC_W-1:0]   viol_ld_pc,
  input  logic [PC_W-1:0]   viol_st_pc,
  input  logic              iss_vld,
  input  logic [SET_W-1:0]  iss_set,
  input  logic [INUM_W-1:0] iss_inum,
  output logic              rsp_vld,
  output logic              rsp_set_vld,
  output logic [SET_W-1:0]  rsp_set_id,
  output logic              rsp_has_dep,
  output logic [INUM_W-1:0] rsp_dep_inum
);
  logic [IDX_W-1:0]  f_idx, ld_idx, st_idx;
  logic              f_set_vld;
  logic [SET_W-1:0]  f_set_id;
  logic [SET_W-1:0]  fresh_id;
  logic              fresh_take;
  logic              last_vld;
  logic [INUM_W-1:0] last_inum;
  logic              rec_store;
  logic              unused_pc_bits;

  assign f_idx  = fetch_pc[IDX_MSB:IDX_LSB];
  assign ld_idx = viol_ld_pc[IDX_MSB:IDX_LSB];
  assign st_idx = viol_st_pc[IDX_MSB:IDX_LSB];
  assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_MSB+1], fetch_pc[IDX_LSB-1:0],
                            viol_ld_pc[PC_W-1:IDX_MSB+1], viol_ld_pc[IDX_LSB-1:0],
                            viol_st_pc[PC_W-1:IDX_MSB+1], viol_st_pc[IDX_LSB-1:0]};

  ssp_set_alloc #(.SETS(SETS)) alloc_i (
    .clk(clk), .rst(rst), .take(fresh_take), .next_id(fresh_id)
  );

  ssp_id_table #(.ENTRIES(ENTRIES), .SETS(SETS)) ids_i (
    .clk(clk), .rst(rst),
    .look_idx(f_idx), .look_vld(f_set_vld), .look_id(f_set_id),
    .trn_we(viol_vld), .trn_ld_idx(ld_idx), .trn_st_idx(st_idx),
    .fresh_id(fresh_id), .fresh_take(fresh_take)
  );

  assign rec_store = fetch_vld && fetch_is_store && f_set_vld;

  ssp_last_store #(.SETS(SETS), .INUM_W(INUM_W)) last_i (
    .clk(clk), .rst(rst),
    .rd_set(f_set_id), .rd_vld(last_vld), .rd_inum(last_inum),
    .wr_en(rec_store), .wr_set(f_set_id), .wr_inum(fetch_inum),
    .clr_en(iss_vld), .clr_set(iss_set), .clr_inum(iss_inum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld      <= 1'b0;
      rsp_set_vld  <= 1'b0;
      rsp_set_id   <= '0;
      rsp_has_dep  <= 1'b0;
      rsp_dep_inum <= '0;
    end else begin
      rsp_vld      <= fetch_vld;
      rsp_set_vld  <= fetch_vld && f_set_vld;
      rsp_set_id   <= fetch_vld ? f_set_id : '0;
      rsp_has_dep  <= fetch_vld && f_set_vld && last_vld;
      rsp_dep_inum <= (fetch_vld && f_set_vld) ? last_inum : '0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rsp_vld); // R1
  AST_FETCH_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |=> rsp_vld); // R5
  AST_DEP_NEEDS_SET: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && rsp_has_dep) |-> rsp_set_vld); // R8
  AST_NODEP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && !rsp_has_dep) |-> rsp_dep_inum == '0); // R6
endmodule

// File: tb/ssp_predictor_tb.sv
module ssp_predictor_tb_top;
  localparam int PC_W = 32;
  localparam int INUM_W = 16;
  localparam int SETS = 32;
  localparam int SET_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_vld = 0, fetch_is_store = 0;
  logic [PC_W-1:0] fetch_pc = '0, viol_ld_pc = '0, viol_st_pc = '0;
  logic [INUM_W-1:0] fetch_inum = '0, iss_inum = '0;
  logic viol_vld = 0, iss_vld = 0;
  logic [SET_W-1:0] iss_set = '0;
  logic rsp_vld, rsp_set_vld, rsp_has_dep;
  logic [SET_W-1:0] rsp_set_id;
  logic [INUM_W-1:0] rsp_dep_inum;

  always #2 clk = ~clk;

  ssp_predictor dut_i (
    .clk(clk), .rst(rst),
    .fetch_vld(fetch_vld), .fetch_is_store(fetch_is_store),
    .fetch_pc(fetch_pc), .fetch_inum(fetch_inum),
    .viol_vld(viol_vld), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .iss_vld(iss_vld), .iss_set(iss_set), .iss_inum(iss_inum),
    .rsp_vld(rsp_vld), .rsp_set_vld(rsp_set_vld), .rsp_set_id(rsp_set_id),
    .rsp_has_dep(rsp_has_dep), .rsp_dep_inum(rsp_dep_inum)
  );

  // behavioural reference
  bit m_v[256];
  int m_id[256];
  bit l_v[SETS];
  int l_n[SETS];
  int alloc_cnt;
  bit e_vld, e_setv, e_dep;
  int e_set, e_inum;
  bit e_store;
  int e_store_inum;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_id[i] = 0; end
      foreach (l_v[i]) begin l_v[i] = 0; l_n[i] = 0; end
      alloc_cnt = 0;
      e_vld = 0;
    end else begin
      int fi, li, si, sid;
      bit sv, ldv;
      int ldid;
      fi = int'(fetch_pc[9:2]);
      sv = m_v[fi];
      sid = sv ? m_id[fi] : 0;
      e_vld = fetch_vld;
      e_setv = fetch_vld && sv;
      e_set = fetch_vld ? sid : 0;
      e_dep = fetch_vld && sv && l_v[sid];
      e_inum = e_dep ? l_n[sid] : 0;
      e_store = fetch_vld && fetch_is_store && sv;
      e_store_inum = int'(fetch_inum);
      if (iss_vld && l_v[iss_set] && l_n[iss_set] == int'(iss_inum))
        l_v[iss_set] = 0;
      if (e_store) begin l_v[sid] = 1; l_n[sid] = int'(fetch_inum); end
      if (viol_vld) begin
        li = int'(viol_ld_pc[9:2]);
        si = int'(viol_st_pc[9:2]);
        ldv = m_v[li];
        ldid = m_id[li];
        if (!ldv) begin
          m_v[li] = 1; m_id[li] = alloc_cnt;
          m_v[si] = 1; m_id[si] = alloc_cnt;
          alloc_cnt = (alloc_cnt + 1) % SETS;
        end else begin
          m_v[si] = 1; m_id[si] = ldid;
        end
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  string cur_tag = "R1";
  bit finished = 0;
  int pend_set[$];
  int pend_inum[$];

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(cur_tag, "rsp_vld", int'(rsp_vld), int'(e_vld));
    if (e_vld) begin
      check(cur_tag, "rsp_set_vld", int'(rsp_set_vld), int'(e_setv));
      check(cur_tag, "rsp_set_id", int'(rsp_set_id), e_set);
      check(cur_tag, "rsp_has_dep", int'(rsp_has_dep), int'(e_dep));
      check(cur_tag, "rsp_dep_inum", int'(rsp_dep_inum), e_inum);
      if (e_store) begin
        pend_set.push_back(e_set);
        pend_inum.push_back(e_store_inum);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    fetch_vld = 0; viol_vld = 0; iss_vld = 0; fetch_is_store = 0;
  endtask

  task automatic fetch(bit st, int idx, int upper, int inum);
    fetch_vld = 1; fetch_is_store = st;
    fetch_pc = PC_W'((upper << 10) | (idx << 2));
    fetch_inum = INUM_W'(inum);
  endtask

  task automatic viol(int lidx, int sidx);
    viol_vld = 1;
    viol_ld_pc = PC_W'(lidx << 2);
    viol_st_pc = PC_W'(sidx << 2);
  endtask

  task automatic issue(int set, int inum);
    iss_vld = 1; iss_set = SET_W'(set); iss_inum = INUM_W'(inum);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = "R1";
    check("R1", "rsp_vld after reset", int'(rsp_vld), 0);
    fetch(0, 8'h40, 0, 1); tick();                 // fresh table: no set
    fetch(1, 8'h80, 0, 2); tick();
    cur_tag = "R8";
    fetch(1, 8'h80, 0, 3); tick();                 // unset store left nothing
    // R10: violation and lookup of the same load in one cycle
    cur_tag = "R10";
    viol(8'h40, 8'h80); fetch(0, 8'h40, 0, 4); tick();
    check("R10", "old contents seen", int'(rsp_set_vld), 0);
    cur_tag = "R7";
    fetch(1, 8'h80, 0, 5); tick();                 // first store, no dep
    cur_tag = "R6";
    fetch(0, 8'h40, 0, 6); tick();
    check("R6", "load waits on store 5", int'(rsp_dep_inum), 5);
    cur_tag = "R7";
    fetch(1, 8'h80, 0, 7); tick();                 // chained on 5
    check("R7", "store ordered behind 5", int'(rsp_dep_inum), 5);
    cur_tag = "R2";
    fetch(0, 8'h40, 3, 8); tick();                 // aliasing upper bits
    check("R2", "alias shares entry", int'(rsp_dep_inum), 7);
    cur_tag = "R9";
    issue(0, 5); tick();                           // stale, ignored
    fetch(0, 8'h40, 0, 9); tick();
    check("R9", "stale issue no effect", int'(rsp_has_dep), 1);
    issue(0, 7); tick();
    fetch(0, 8'h40, 0, 10); tick();
    check("R9", "retired entry", int'(rsp_has_dep), 0);
    cur_tag = "R4";
    viol(8'h40, 8'h90); tick();
    fetch(1, 8'h90, 0, 11); tick();
    check("R4", "store joins load set", int'(rsp_set_id), 0);
    cur_tag = "R3";
    viol(8'h50, 8'h90); tick();                    // store had set, load fresh
    fetch(1, 8'h90, 0, 12); tick();
    check("R3", "fresh set for both", int'(rsp_set_id), 1);
    fetch(0, 8'h50, 0, 13); tick();
    check("R3", "load in fresh set", int'(rsp_dep_inum), 12);
    // R10: store fetch beats retiring issue on the same set
    cur_tag = "R10";
    fetch(1, 8'h90, 0, 14); issue(1, 12); tick();
    fetch(0, 8'h50, 0, 15); tick();
    check("R10", "new store survives issue", int'(rsp_dep_inum), 14);
    // R11: walk the counter past 31
    cur_tag = "R11";
    for (int k = 0; k < 31; k++) begin viol(8'hA0 + k, 8'hC0 + k); tick(); end
    fetch(0, 8'hA0 + 29, 0, 16); tick();
    check("R11", "last id 31", int'(rsp_set_id), 31);
    fetch(0, 8'hA0 + 30, 0, 17); tick();
    check("R11", "wrapped to 0", int'(rsp_set_id), 0);
    // random mix
    cur_tag = "R5";
    pend_set.delete(); pend_inum.delete();
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) != 0)
        fetch(1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 7), 100 + c);
      if ($urandom_range(0, 9) == 0)
        viol($urandom_range(0, 15), $urandom_range(0, 15));
      if (pend_set.size() > 0 && $urandom_range(0, 2) == 0) begin
        issue(pend_set.pop_front(), pend_inum.pop_front());
      end else if ($urandom_range(0, 15) == 0) begin
        issue($urandom_range(0, SETS - 1), $urandom_range(0, 200));
      end
      tick();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule